// File: doc/BRIEF.md
# L1 Line Coherence Controller with Post-Transfer Lock

This block is the per-line state machine of a MOESI-style first-level cache. Each cycle it looks at three request ports: a trigger port that carries internal completions, an external snoop port, and the local processor request port. It serves one event and raises the action strobes that the surrounding queues and miss logic act on. The data arrays, the network and most of the miss and transient handling are outside this block. Only enough of the miss path is modelled to get lines into and out of the states that matter here.

When a line finishes moving from L2 into L1, it does not go back to a plain stable state. It enters a locked ready state instead. In a ready state every coherent snoop gets a protocol stall: the snoop stays in its queue, and the local port is presented in the same cycle. Only a local request can move the line out of the lock. This means a core that was waiting on the transfer always gets at least one access before remote traffic can take the line away, which removes the starvation loop in which snoops and transfers chased each other forever.

Top module: `l1_line_fsm`

## Requirements
- R1: `line_state` uses this encoding. Stable states: I=0, S=1, O=2, M=3, MM=4. Ready states: IR=5, SR=6, OR=7, MR=8, MMR=9. Transfer states: IT=10, ST=11, OT=12, MT=13, MMT=14. Miss states: IS=15, IM=16, SM=17, OM=18, IM_F=19, SM_F=20, OM_F=21, MM_F=22. Reset gives I. With no valid input, every strobe is low and the state holds.
- R2: The ports have a fixed priority: trigger, then external, then local. While `trig_valid` is high, neither of the other ports gets any strobe. If an external event is serviced, the local port gets no strobe in that cycle. If the external event is protocol-stalled, the local port is served in the same cycle. Every serviced local request raises `loc_pop` for one cycle.
- R3: Trigger codes are 0 = begin transfer, 1 = transfer done, 2 = fill shared, 3 = fill exclusive. Begin moves a stable state s to s+10. Done moves a transfer state t to ready state t-5 and raises `wake`. Every trigger raises `trig_pop`. A trigger code that does not apply to the current state changes nothing else.
- R4: Snoop codes are 0 = other GETX, 1 = other GETS, 2 = non-coherent DMA GETS, 3 = merged GETS, 4 = GETS without migration, 5 = invalidate. In a ready state, each of these raises `snoop_stall`, not `ext_pop`, and leaves the state unchanged. A ready state is left only through a local request.
- R5: In a transfer state, snoop codes 0 to 5 raise `snoop_stall`. A local flush raises `req_stall` without a pop. A local load, ifetch, store or evict raises `park`.
- R6: Local codes are 0 = load, 1 = ifetch, 2 = store, 3 = flush, 4 = evict to L2. An evict in a ready state raises `park` and leaves the state unchanged. An evict in a stable state is popped and changes nothing.
- R7: In I or IR: a load or ifetch goes to IS and raises `issue_gets`. A store goes to IM and raises `issue_getx`. A flush goes to IM_F and raises `issue_getf`.
- R8: In S or SR: a load or ifetch is a `load_hit` and the line ends in S. A store goes to SM with `issue_getx`. A flush goes to SM_F with `issue_getf`.
- R9: In O or OR: a load or ifetch is a `load_hit` and the line ends in O. A store goes to OM with `issue_getx` and `dec_msg`. A flush goes to OM_F with `issue_getf` and `dec_msg`.
- R10: In M or MR: a load or ifetch is a `load_hit` ending in M, and a store is a `store_hit` ending in MM. In MM or MMR: a load or ifetch is a `load_hit` ending in MM, and a store is a `store_hit` ending in MM. A flush from M, MM, MR or MMR goes to MM_F with `issue_getf` and `dec_msg`.
- R11: A local load, ifetch, store or flush served in a ready state also raises `wake`.
- R12: A fill is accepted only in a miss state. The targets are:
  - IS goes to S on a shared fill and to M on an exclusive fill.
  - IM, SM and OM go to MM.
  - The four flush-miss states go to I.

  Each accepted fill raises `wake`. In a miss state, local codes 0 to 4 raise `park`, and snoop codes 0 to 5 raise `snoop_stall`.
- R13: In a stable state, snoops are popped with `ext_pop`:
  - Codes 0 and 5 go to I.
  - Codes 1, 3 and 4 move M or MM to O, and leave other states as they are.
  - Code 2 changes nothing.

  Snoop codes 6 and 7 and local codes 5 to 7 are popped with no other effect in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger port holds an event |
| trig_kind | input | 2 | Trigger code (R3) |
| ext_valid | input | 1 | Snoop port holds an event |
| ext_kind | input | 3 | Snoop code (R4) |
| loc_valid | input | 1 | Local port holds a request |
| loc_kind | input | 3 | Local code (R6) |
| line_state | output | 5 | Current line state (R1) |
| trig_pop | output | 1 | Trigger event consumed |
| ext_pop | output | 1 | Snoop consumed |
| snoop_stall | output | 1 | Snoop left queued, next port checked |
| loc_pop | output | 1 | Local request consumed |
| req_stall | output | 1 | Local request left queued |
| park | output | 1 | Local request moved aside until wake |
| wake | output | 1 | Replay parked requests |
| issue_gets | output | 1 | Send shared read request |
| issue_getx | output | 1 | Send exclusive request |
| issue_getf | output | 1 | Send flush request |
| load_hit | output | 1 | Load or ifetch served from the line |
| store_hit | output | 1 | Store served into the line |
| dec_msg | output | 1 | Expected-message count minus one |

## Verification
A snoop's protocol stall and the service of a local request can happen in the same cycle. This is the mechanism that breaks the lock. The bench provokes it by holding a snoop and a local load or store together while the line is in a ready, transfer or miss state. It then requires `snoop_stall` alongside the local strobe: a hit with `wake` in a ready state, `park` in a transfer or miss state. It also requires the matching next state. The same pair is then presented on a stable line, where the snoop must be popped alone and the local request must get nothing. A trigger presented with both ports valid must be the only event served.

// File: rtl/l1_line_fsm.sv
`timescale 1ns/1ps
module l1_line_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_valid,
  input  logic [1:0] trig_kind,
  input  logic       ext_valid,
  input  logic [2:0] ext_kind,
  input  logic       loc_valid,
  input  logic [2:0] loc_kind,
  output logic [4:0] line_state,
  output logic       trig_pop,
  output logic       ext_pop,
  output logic       snoop_stall,
  output logic       loc_pop,
  output logic       req_stall,
  output logic       park,
  output logic       wake,
  output logic       issue_gets,
  output logic       issue_getx,
  output logic       issue_getf,
  output logic       load_hit,
  output logic       store_hit,
  output logic       dec_msg
);
  localparam logic [4:0] ST_I = 5'd0, ST_S = 5'd1, ST_O = 5'd2, ST_M = 5'd3, ST_MM = 5'd4;
  localparam logic [4:0] RDY_OFS = 5'd5, XFR_OFS = 5'd10;
  localparam logic [4:0] ST_IS = 5'd15, ST_IM = 5'd16, ST_SM = 5'd17, ST_OM = 5'd18;
  localparam logic [4:0] ST_IMF = 5'd19, ST_SMF = 5'd20, ST_OMF = 5'd21, ST_MMF = 5'd22;

  localparam logic [1:0] TRG_BEGIN = 2'd0, TRG_DONE = 2'd1, TRG_FILL_EX = 2'd3;

  localparam logic [2:0] SNP_GETX = 3'd0, SNP_GETS = 3'd1, SNP_MERGED = 3'd3;
  localparam logic [2:0] SNP_NOMIG = 3'd4, SNP_INV = 3'd5;

  localparam logic [2:0] REQ_LOAD = 3'd0, REQ_IFETCH = 3'd1, REQ_STORE = 3'd2;
  localparam logic [2:0] REQ_FLUSH = 3'd3, REQ_EVICT = 3'd4;

  logic [4:0] state_q, state_d, base;
  logic       in_stable, in_ready, in_xfer, in_miss;
  logic       snp_coherent, is_read, take_local;

  assign in_stable    = state_q <= ST_MM;
  assign in_ready     = (state_q >= RDY_OFS) && (state_q < XFR_OFS);
  assign in_xfer      = (state_q >= XFR_OFS) && (state_q < ST_IS);
  assign in_miss      = state_q >= ST_IS;
  assign base         = in_ready ? state_q - RDY_OFS : state_q;
  assign snp_coherent = ext_kind <= SNP_INV;
  assign is_read      = (loc_kind == REQ_LOAD) || (loc_kind == REQ_IFETCH);
  assign line_state   = state_q;

  always_comb begin
    state_d     = state_q;
    trig_pop    = 1'b0;
    ext_pop     = 1'b0;
    snoop_stall = 1'b0;
    loc_pop     = 1'b0;
    req_stall   = 1'b0;
    park        = 1'b0;
    wake        = 1'b0;
    issue_gets  = 1'b0;
    issue_getx  = 1'b0;
    issue_getf  = 1'b0;
    load_hit    = 1'b0;
    store_hit   = 1'b0;
    dec_msg     = 1'b0;
    take_local  = 1'b0;

    if (trig_valid) begin
      trig_pop = 1'b1;
      case (trig_kind)
        TRG_BEGIN: if (in_stable) state_d = state_q + XFR_OFS;
        TRG_DONE: if (in_xfer) begin
          state_d = state_q - RDY_OFS;
          wake    = 1'b1;
        end
        default: if (in_miss) begin
          wake = 1'b1;
          case (state_q)
            ST_IS:                  state_d = (trig_kind == TRG_FILL_EX) ? ST_M : ST_S;
            ST_IM, ST_SM, ST_OM:    state_d = ST_MM;
            default:                state_d = ST_I;
          endcase
        end
      endcase
    end else begin
      take_local = !ext_valid;
      if (ext_valid) begin
        if (!in_stable && snp_coherent) begin
          snoop_stall = 1'b1;
          take_local  = 1'b1;
        end else begin
          ext_pop = 1'b1;
          if (in_stable) begin
            if (ext_kind == SNP_GETX || ext_kind == SNP_INV)
              state_d = ST_I;
            else if ((ext_kind == SNP_GETS || ext_kind == SNP_MERGED || ext_kind == SNP_NOMIG) &&
                     (state_q == ST_M || state_q == ST_MM))
              state_d = ST_O;
          end
        end
      end

      if (take_local && loc_valid) begin
        if (loc_kind > REQ_EVICT) begin
          loc_pop = 1'b1;
        end else if (in_xfer) begin
          if (loc_kind == REQ_FLUSH) req_stall = 1'b1;
          else                       park      = 1'b1;
        end else if (in_miss) begin
          park = 1'b1;
        end else if (loc_kind == REQ_EVICT) begin
          if (in_ready) park    = 1'b1;
          else          loc_pop = 1'b1;
        end else begin
          loc_pop = 1'b1;
          wake    = in_ready;
          case (base)
            ST_I: begin
              if (is_read)                     begin state_d = ST_IS;  issue_gets = 1'b1; end
              else if (loc_kind == REQ_STORE)  begin state_d = ST_IM;  issue_getx = 1'b1; end
              else                             begin state_d = ST_IMF; issue_getf = 1'b1; end
            end
            ST_S: begin
              if (is_read)                     begin state_d = ST_S;   load_hit   = 1'b1; end
              else if (loc_kind == REQ_STORE)  begin state_d = ST_SM;  issue_getx = 1'b1; end
              else                             begin state_d = ST_SMF; issue_getf = 1'b1; end
            end
            ST_O: begin
              if (is_read) begin
                state_d  = ST_O;
                load_hit = 1'b1;
              end else begin
                state_d    = (loc_kind == REQ_STORE) ? ST_OM : ST_OMF;
                issue_getx = loc_kind == REQ_STORE;
                issue_getf = loc_kind == REQ_FLUSH;
                dec_msg    = 1'b1;
              end
            end
            default: begin
              if (is_read) begin
                state_d  = base;
                load_hit = 1'b1;
              end else if (loc_kind == REQ_STORE) begin
                state_d   = ST_MM;
                store_hit = 1'b1;
              end else begin
                state_d    = ST_MMF;
                issue_getf = 1'b1;
                dec_msg    = 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_I;
    else        state_q <= state_d;
  end
endmodule

module l1_line_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_valid,
  input logic [1:0] trig_kind,
  input logic       ext_valid,
  input logic [2:0] ext_kind,
  input logic       loc_valid,
  input logic [2:0] loc_kind,
  input logic [4:0] line_state,
  input logic       trig_pop,
  input logic       ext_pop,
  input logic       snoop_stall,
  input logic       loc_pop,
  input logic       req_stall,
  input logic       park,
  input logic       wake,
  input logic       issue_gets,
  input logic       issue_getx,
  input logic       issue_getf
);
  logic locked, moving;
  assign locked = (line_state >= 5'd5) && (line_state <= 5'd9);
  assign moving = (line_state >= 5'd10) && (line_state <= 5'd14);

  a_r1_change_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_state) |-> $past(trig_pop || ext_pop || loc_pop));

  a_r2_trigger_first: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> !(ext_pop || loc_pop || snoop_stall || park || req_stall));

  a_r3_done_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_kind == 2'd1 && moving) |=> line_state == 5'($past(line_state) - 5'd5));

  a_r4_snoop_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !trig_valid && ext_valid && ext_kind <= 3'd5) |-> (snoop_stall && !ext_pop));

  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !loc_pop) |=> $stable(line_state));

  a_r6_park_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(park && (loc_pop || req_stall)));

  a_r7_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_gets, issue_getx, issue_getf}));

  a_r11_exit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && loc_pop && loc_kind <= 3'd3) |-> wake);

  logic unused_ok;
  assign unused_ok = loc_valid;
endmodule

bind l1_line_fsm l1_line_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_kind(trig_kind),
  .ext_valid(ext_valid), .ext_kind(ext_kind), .loc_valid(loc_valid), .loc_kind(loc_kind),
  .line_state(line_state), .trig_pop(trig_pop), .ext_pop(ext_pop), .snoop_stall(snoop_stall),
  .loc_pop(loc_pop), .req_stall(req_stall), .park(park), .wake(wake),
  .issue_gets(issue_gets), .issue_getx(issue_getx), .issue_getf(issue_getf)
);

// File: tb/l1_line_fsm_bench.sv
`timescale 1ns/1ps
module l1_line_fsm_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_valid = 1'b0, ext_valid = 1'b0, loc_valid = 1'b0;
  logic [1:0] trig_kind = '0;
  logic [2:0] ext_kind = '0, loc_kind = '0;
  logic [4:0] line_state;
  logic trig_pop, ext_pop, snoop_stall, loc_pop, req_stall, park, wake;
  logic issue_gets, issue_getx, issue_getf, load_hit, store_hit, dec_msg;

  always #4 clk = ~clk;

  l1_line_fsm u_l1_line_fsm (.*);

  localparam logic [12:0] TP = 13'h1000, EP = 13'h0800, SS = 13'h0400, LP = 13'h0200;
  localparam logic [12:0] RS = 13'h0100, PK = 13'h0080, WK = 13'h0040, GS = 13'h0020;
  localparam logic [12:0] GX = 13'h0010, GF = 13'h0008, LH = 13'h0004, SH = 13'h0002;
  localparam logic [12:0] DM = 13'h0001, NONE = 13'h0000;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [12:0] q_strobe[$];
  logic [4:0]  q_state[$];
  string       q_tag[$];

  wire [12:0] strobes = {trig_pop, ext_pop, snoop_stall, loc_pop, req_stall, park, wake,
                         issue_gets, issue_getx, issue_getf, load_hit, store_hit, dec_msg};

  task automatic step(input logic tv, input logic [1:0] tk, input logic ev, input logic [2:0] ek,
                      input logic lv, input logic [2:0] lk, input logic [12:0] exp_s,
                      input logic [4:0] exp_st, input string tag);
    @(negedge clk);
    trig_valid = tv; trig_kind = tk; ext_valid = ev; ext_kind = ek;
    loc_valid = lv; loc_kind = lk;
    q_strobe.push_back(exp_s);
    q_state.push_back(exp_st);
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q_strobe.size() > 0) begin
        logic [12:0] es;
        logic [4:0]  est;
        string t;
        es = q_strobe.pop_front(); est = q_state.pop_front(); t = q_tag.pop_front();
        checks++;
        if (strobes !== es) begin
          errors++;
          $display("FAIL %s strobes actual=%h expected=%h", t, strobes, es);
        end
        @(posedge clk);
        #1;
        checks++;
        if (line_state !== est) begin
          errors++;
          $display("FAIL %s state actual=%0d expected=%0d", t, line_state, est);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0,0,0,0,0,0, NONE, 5'd0, "R1 reset idle");
    step(0,0,0,0,1,0, LP|GS, 5'd15, "R7 I load to IS");
    step(1,2,0,0,0,0, TP|WK, 5'd1, "R12 IS shared fill to S");
    step(1,0,0,0,0,0, TP, 5'd11, "R3 S begin transfer to ST");
    step(0,0,1,0,1,0, SS|PK, 5'd11, "R5 ST snoop stall with parked load");
    step(0,0,0,0,1,3, RS, 5'd11, "R5 ST flush stalled");
    step(1,1,1,0,1,0, TP|WK, 5'd6, "R2 R3 done wins over both ports");
    step(0,0,1,1,1,0, SS|LP|LH|WK, 5'd1, "R4 R8 R11 SR snoop stall plus load hit");
    step(0,0,1,5,1,0, EP, 5'd0, "R13 R2 S invalidate alone");
    step(0,0,0,0,1,7, LP, 5'd0, "R13 reserved local code");
    step(1,1,0,0,0,0, TP, 5'd0, "R3 done in I has no effect");
    step(0,0,0,0,1,4, LP, 5'd0, "R6 evict in stable");
    step(0,0,0,0,1,1, LP|GS, 5'd15, "R7 I ifetch to IS");
    step(1,3,0,0,0,0, TP|WK, 5'd3, "R12 IS exclusive fill to M");
    step(1,0,0,0,0,0, TP, 5'd13, "R3 M begin to MT");
    step(1,1,0,0,0,0, TP|WK, 5'd8, "R3 MT done to MR");
    step(0,0,0,0,1,4, PK, 5'd8, "R6 MR evict parked");
    step(0,0,1,2,0,0, SS, 5'd8, "R4 MR DMA snoop stalled");
    step(0,0,1,4,0,0, SS, 5'd8, "R4 MR no-migrate snoop stalled");
    step(0,0,1,6,0,0, EP, 5'd8, "R13 reserved snoop popped");
    step(0,0,0,0,1,2, LP|SH|WK, 5'd4, "R10 R11 MR store hit to MM");
    step(0,0,0,0,1,0, LP|LH, 5'd4, "R10 MM load hit");
    step(0,0,1,1,1,0, EP, 5'd2, "R13 MM other GETS to O");
    step(1,0,0,0,0,0, TP, 5'd12, "R3 O begin to OT");
    step(1,1,0,0,0,0, TP|WK, 5'd7, "R3 OT done to OR");
    step(0,0,0,0,1,2, LP|GX|DM|WK, 5'd18, "R9 OR store to OM");
    step(0,0,1,0,1,0, SS|PK, 5'd18, "R12 OM snoop stall and park");
    step(1,2,0,0,0,0, TP|WK, 5'd4, "R12 OM fill to MM");
    step(1,0,0,0,0,0, TP, 5'd14, "R3 MM begin to MMT");
    step(1,1,0,0,0,0, TP|WK, 5'd9, "R3 MMT done to MMR");
    step(0,0,0,0,1,2, LP|SH|WK, 5'd4, "R10 MMR store hit");
    step(0,0,0,0,1,3, LP|GF|DM, 5'd22, "R10 MM flush to MM_F");
    step(1,2,0,0,0,0, TP|WK, 5'd0, "R12 MM_F fill to I");
    step(1,0,0,0,0,0, TP, 5'd10, "R3 I begin to IT");
    step(1,1,0,0,0,0, TP|WK, 5'd5, "R3 IT done to IR");
    step(0,0,1,3,1,2, SS|LP|GX|WK, 5'd16, "R4 R7 IR merged stall plus store");
    step(1,3,0,0,0,0, TP|WK, 5'd4, "R12 IM fill to MM");
    step(0,0,1,0,0,0, EP, 5'd0, "R13 MM other GETX to I");
    step(1,0,0,0,0,0, TP, 5'd10, "R3 I begin to IT again");
    step(1,1,0,0,0,0, TP|WK, 5'd5, "R3 IT done to IR again");
    step(0,0,0,0,1,3, LP|GF|WK, 5'd19, "R7 IR flush to IM_F");
    step(1,2,0,0,0,0, TP|WK, 5'd0, "R12 IM_F fill to I");
    step(0,0,0,0,1,0, LP|GS, 5'd15, "R7 I load again");
    step(1,2,0,0,0,0, TP|WK, 5'd1, "R12 IS fill to S again");
    step(1,0,0,0,0,0, TP, 5'd11, "R3 S begin to ST");
    step(1,1,0,0,0,0, TP|WK, 5'd6, "R3 ST done to SR");
    step(0,0,0,0,1,3, LP|GF|WK, 5'd20, "R8 SR flush to SM_F");
    step(0,0,0,0,0,0, NONE, 5'd20, "R1 idle holds state");
    @(negedge clk);
    trig_valid = 0; ext_valid = 0; loc_valid = 0;
    wait (q_strobe.size() == 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule